// File: doc/BRIEF.md
# Chunked Hamming Parity Generator for NAND Page Data

This block watches bytes passing between a memory controller and a NAND device and folds them into a single-error-correcting Hamming code, one code for every 256 bytes of page data. Software or a transfer engine strobes a clear before a page moves, then raises an enable for the data area and drops it for the spare area. Spare-area bytes therefore leave the code untouched.

When the last byte of a chunk is taken, the block does three things. It latches a result word that packs the column parity below the line parity. It pulses a result-valid flag for one cycle. It clears its accumulator so that the next chunk starts fresh.

A second output presents the code in the three-byte form that is written to the spare area. That form is the result word shifted up by two places and inverted. An erased chunk (all 0xFF) therefore yields all-ones bytes, which is what an erased spare area reads back.

Top module: `ecc_chunk_hamming`

## Requirements
- R1: After reset, res_word is 0, res_vld is 0 and res_code is 24'hFFFFFF.
- R2: A byte is taken only in a cycle where byte_vld and ecc_en are both 1 and ecc_clr is 0. A cycle with byte_vld=0, or with ecc_en=0, changes neither the byte position nor the parity.
- R3: The 256th byte taken since the last clear or the last result is the end of a chunk. Counting from the clock edge that takes it, res_vld is 1 for exactly the next cycle, and res_word carries the new value in that same cycle. res_vld is 0 at all other times.
- R4: res_word[5:0] is the column parity over the XOR of all bytes of the chunk. Bit 2j+1 is the XOR of the data bits whose position p has bit j of p equal to 1. Bit 2j is the XOR of the data bits whose position has that bit equal to 0. This holds for j = 0, 1, 2.
- R5: res_word[20:6] is the line parity, and r = XOR of the bits of a byte is that byte's row parity. For k = 0..6, line bit 2k+1 is the XOR of r over the bytes whose chunk index has bit k equal to 1, and line bit 2k is the XOR of r over the bytes where that bit is 0. Line bit 14 is the XOR of r over the bytes with index bit 7 equal to 1. res_word[31:21] is 0.
- R6: res_code equals the bitwise inverse of (res_word << 2), kept to 24 bits. res_code[23:16] is the first stored byte, then [15:8], then [7:0].
- R7: After a chunk ends, accumulation restarts at index 0 with zero parity. Consecutive chunks give independent results.
- R8: ecc_clr returns the byte position and the parity to zero, and a byte offered in the same cycle is discarded. res_word and res_vld are not changed by it.
- R9: A chunk of 256 bytes of 0xFF gives res_word = 0 and res_code = 24'hFFFFFF.
- R10: res_word and res_code hold their value between result pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ecc_clr | input | 1 | Clears the byte position and the parity |
| ecc_en | input | 1 | Parity accumulation enable |
| byte_vld | input | 1 | A byte is present on byte_data |
| byte_data | input | 8 | Data byte |
| res_word | output | 32 | Result word: column parity [5:0], line parity [20:6] |
| res_vld | output | 1 | One-cycle pulse when a new result is loaded |
| res_code | output | 24 | Stored three-byte code, first byte in [23:16] |

## Verification
A result is due one cycle after the clock edge that takes the final byte of a chunk, because a single register sits between the inputs and res_word, res_vld and res_code. The driver changes inputs on falling edges. When it drives a chunk's last byte it records the expected word together with the cycle in which the result must appear. A monitor sampling on falling edges pops each entry when res_vld is seen and checks the word, the code and the arrival cycle. Any pulse that is unexpected or longer than one cycle counts as a failure. Idle, disabled, cleared and colliding-clear bytes are placed between the taken bytes, so their lack of effect shows up in the next expected result.

// File: rtl/hamm_chunk_pkg.sv
package hamm_chunk_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned STORE_W = 24;
   localparam int unsigned STORE_SHIFT = 2;

   function automatic int unsigned line_width(input int unsigned idx_w);
      return 2 * idx_w - 1;
   endfunction

   function automatic int unsigned col_width(input int unsigned data_w);
      return 2 * $clog2(data_w);
   endfunction
endpackage

// File: rtl/hc_index_ctr.sv
module hc_index_ctr #(
   parameter int unsigned CHUNK_BYTES = 256,
   localparam int unsigned IDX_W = $clog2(CHUNK_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             take,
   output logic [IDX_W-1:0] idx,
   output logic             last
);
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(CHUNK_BYTES - 1);

   assign last = take && (idx == IDX_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        idx <= '0;
      else if (clr)      idx <= '0;
      else if (last)     idx <= '0;
      else if (take)     idx <= idx + 1'b1;
   end
endmodule

// File: rtl/hc_line_acc.sv
module hc_line_acc #(
   parameter int unsigned IDX_W = 8,
   localparam int unsigned LP_W = 2 * IDX_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             take,
   input  logic             last,
   input  logic [IDX_W-1:0] idx,
   input  logic             row_par,
   output logic [LP_W-1:0]  acc,
   output logic [LP_W-1:0]  nxt
);
   logic [LP_W-1:0] contrib;

   generate
      for (genvar k = 0; k < IDX_W - 1; k++) begin : g_pair
         assign contrib[2*k]   = row_par & ~idx[k];
         assign contrib[2*k+1] = row_par &  idx[k];
      end
   endgenerate
   // top index bit keeps only its odd half; the even half is implied
   assign contrib[LP_W-1] = row_par & idx[IDX_W-1];

   assign nxt = acc ^ contrib;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               acc <= '0;
      else if (clr)             acc <= '0;
      else if (take && last)    acc <= '0;
      else if (take)            acc <= nxt;
   end
endmodule

// File: rtl/hc_col_fold.sv
module hc_col_fold #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned SEL_W = $clog2(DATA_W),
   localparam int unsigned CP_W  = 2 * SEL_W
) (
   input  logic [DATA_W-1:0] fold,
   output logic [CP_W-1:0]   cp
);
   generate
      for (genvar j = 0; j < SEL_W; j++) begin : g_sel
         logic [DATA_W-1:0] hi_m;
         logic [DATA_W-1:0] lo_m;
         for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            if (((b >> j) & 1) == 1) begin : g_hi
               assign hi_m[b] = fold[b];
               assign lo_m[b] = 1'b0;
            end else begin : g_lo
               assign hi_m[b] = 1'b0;
               assign lo_m[b] = fold[b];
            end
         end
         assign cp[2*j+1] = ^hi_m;
         assign cp[2*j]   = ^lo_m;
      end
   endgenerate
endmodule

// File: rtl/ecc_chunk_hamming.sv
module ecc_chunk_hamming
   import hamm_chunk_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CHUNK_BYTES = 256,
   parameter bit          REG_CODE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ecc_clr,
   input  logic              ecc_en,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   output logic [WORD_W-1:0] res_word,
   output logic              res_vld,
   output logic [STORE_W-1:0] res_code
);
   localparam int unsigned IDX_W = $clog2(CHUNK_BYTES);
   localparam int unsigned LP_W  = line_width(IDX_W);
   localparam int unsigned CP_W  = col_width(DATA_W);
   localparam int unsigned PAD_W = WORD_W - LP_W - CP_W;

   generate
      if ((1 << IDX_W) != CHUNK_BYTES || CHUNK_BYTES < 4) begin : g_bad_chunk
         $error("CHUNK_BYTES must be a power of two of at least 4");
      end
      if ((1 << $clog2(DATA_W)) != DATA_W || DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be a power of two of at least 2");
      end
      if (LP_W + CP_W + STORE_SHIFT > STORE_W) begin : g_bad_fit
         $error("parity does not fit the stored code");
      end
   endgenerate

   logic              take;
   logic              last;
   logic [IDX_W-1:0]  idx;
   logic [LP_W-1:0]   line_acc;
   logic [LP_W-1:0]   line_nxt;
   logic [DATA_W-1:0] colx;
   logic [DATA_W-1:0] colx_nxt;
   logic [CP_W-1:0]   cp_nxt;
   logic [WORD_W-1:0] word_nxt;
   logic [WORD_W-1:0] word_q;
   logic              vld_q;

   assign take = byte_vld && ecc_en && !ecc_clr;

   hc_index_ctr #(.CHUNK_BYTES(CHUNK_BYTES)) u_idx (
      .clk(clk), .rst_n(rst_n), .clr(ecc_clr), .take(take),
      .idx(idx), .last(last)
   );

   hc_line_acc #(.IDX_W(IDX_W)) u_line (
      .clk(clk), .rst_n(rst_n), .clr(ecc_clr), .take(take), .last(last),
      .idx(idx), .row_par(^byte_data), .acc(line_acc), .nxt(line_nxt)
   );

   assign colx_nxt = colx ^ byte_data;

   hc_col_fold #(.DATA_W(DATA_W)) u_col (
      .fold(colx_nxt), .cp(cp_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          colx <= '0;
      else if (ecc_clr)    colx <= '0;
      else if (last)       colx <= '0;
      else if (take)       colx <= colx_nxt;
   end

   assign word_nxt = {{PAD_W{1'b0}}, line_nxt, cp_nxt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= last;
         if (last) word_q <= word_nxt;
      end
   end

   generate
      if (REG_CODE) begin : g_code_reg
         logic [WORD_W-1:0]  shf_nxt;
         logic [STORE_W-1:0] code_q;
         assign shf_nxt = word_nxt << STORE_SHIFT;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    code_q <= '1;
            else if (last) code_q <= ~shf_nxt[STORE_W-1:0];
         end
         assign res_code = code_q;
      end else begin : g_code_comb
         logic [WORD_W-1:0] shf_q;
         assign shf_q    = word_q << STORE_SHIFT;
         assign res_code = ~shf_q[STORE_W-1:0];
      end
   endgenerate

   assign res_word = word_q;
   assign res_vld  = vld_q;

   // R3
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |=> !res_vld);
   // R3
   vld_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> res_vld);
   // R3
   no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> !res_vld);
   // R7
   chunk_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (idx == '0 && line_acc == '0 && colx == '0));
   // R8
   clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_clr |=> (idx == '0 && line_acc == '0 && colx == '0));
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ecc_clr && !(byte_vld && ecc_en)) |=>
         ($stable(idx) && $stable(line_acc) && $stable(colx)));
   // R10
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_vld |-> ($stable(res_word) && $stable(res_code)));
endmodule

// File: tb/tb_ecc_chunk_hamming.sv
`timescale 1ns/1ps
module tb_ecc_chunk_hamming;
   localparam int CHUNK = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ecc_clr = 1'b0;
   logic        ecc_en = 1'b0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_data = 8'h00;
   logic [31:0] res_word;
   logic        res_vld;
   logic [23:0] res_code;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   int          due_q[$];
   logic [31:0] last_word = 32'h0;
   logic [7:0]  chunk_buf [CHUNK];
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ecc_chunk_hamming dut (
      .clk(clk), .rst_n(rst_n), .ecc_clr(ecc_clr), .ecc_en(ecc_en),
      .byte_vld(byte_vld), .byte_data(byte_data),
      .res_word(res_word), .res_vld(res_vld), .res_code(res_code)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // expected word from the R4/R5 bit definitions, per set bit and per byte
   function automatic logic [31:0] model_word();
      logic [14:0] lp = '0;
      logic [5:0]  cp = '0;
      for (int i = 0; i < CHUNK; i++) begin
         logic r = 1'b0;
         for (int b = 0; b < 8; b++) begin
            if (chunk_buf[i][b]) begin
               r = ~r;
               for (int j = 0; j < 3; j++) cp[2*j + ((b >> j) & 1)] ^= 1'b1;
            end
         end
         if (r) begin
            for (int k = 0; k < 7; k++) lp[2*k + ((i >> k) & 1)] ^= 1'b1;
            if ((i >> 7) & 1) lp[14] ^= 1'b1;
         end
      end
      return {11'b0, lp, cp};
   endfunction

   function automatic logic [23:0] model_code(input logic [31:0] w);
      logic [31:0] s = w << 2;
      return ~s[23:0];
   endfunction

   task automatic drive(input logic [7:0] d, input bit en, input bit vld, input bit clr);
      @(negedge clk);
      byte_data = d; ecc_en = en; byte_vld = vld; ecc_clr = clr;
   endtask

   task automatic idle(input int n);
      repeat (n) drive(8'h00, 1'b0, 1'b0, 1'b0);
   endtask

   function automatic logic [7:0] pattern(input int pat, input int i);
      case (pat)
         0: return 8'h00;
         1: return 8'hFF;
         2: return 8'(i);
         3: return (i == 255) ? 8'h80 : 8'h00;
         5: return (i == 0) ? 8'h01 : 8'h00;
         6: return 8'(i * 37) ^ 8'h5A;
         default: begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            return lfsr[7:0];
         end
      endcase
   endfunction

   // R2: gaps put disabled and non-valid bytes between taken bytes
   task automatic drive_chunk(input int pat, input bit gaps);
      for (int i = 0; i < CHUNK; i++) begin
         chunk_buf[i] = pattern(pat, i);
         if (gaps && (i % 5 == 2)) begin
            drive(8'hC3, 1'b0, 1'b1, 1'b0);
            drive(8'h3C, 1'b1, 1'b0, 1'b0);
         end
         drive(chunk_buf[i], 1'b1, 1'b1, 1'b0);
      end
      exp_q.push_back(model_word());
      due_q.push_back(cyc + 1);
   endtask

   // scoreboard monitor
   bit prev_vld = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (res_vld) begin
            check(!prev_vld, "R3", "pulse longer than one cycle", 32'(prev_vld), 32'h0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R3", "unexpected result pulse", res_word, 32'h0);
            end else begin
               logic [31:0] ew;
               int ed;
               ew = exp_q.pop_front();
               ed = due_q.pop_front();
               check(res_word == ew, "R4/R5", "result word", res_word, ew);
               check(res_word[31:21] == 11'h0, "R5", "upper bits", res_word, ew);
               check(res_code == model_code(ew), "R6", "stored code", 32'(res_code), 32'(model_code(ew)));
               check(cyc == ed, "R3", "result cycle", 32'(cyc), 32'(ed));
               last_word = ew;
            end
         end
         prev_vld = res_vld;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_word == 32'h0, "R1", "reset word", res_word, 32'h0);
      check(res_vld == 1'b0, "R1", "reset valid", 32'(res_vld), 32'h0);
      check(res_code == 24'hFFFFFF, "R1", "reset code", 32'(res_code), 32'hFFFFFF);

      drive_chunk(5, 1'b0); idle(3);
      drive_chunk(1, 1'b0); idle(3);
      check(res_word == 32'h0, "R9", "erased word", res_word, 32'h0);
      check(res_code == 24'hFFFFFF, "R9", "erased code", 32'(res_code), 32'hFFFFFF);
      drive_chunk(2, 1'b0);
      // R7: back-to-back chunk with no idle gap
      drive_chunk(3, 1'b0); idle(3);
      drive_chunk(4, 1'b1); idle(3);
      drive_chunk(6, 1'b1); idle(20);
      check(res_word == last_word, "R10", "word held while idle", res_word, last_word);
      check(res_code == model_code(last_word), "R10", "code held while idle",
            32'(res_code), 32'(model_code(last_word)));

      // R8: partial chunk, clear with a colliding byte, then a full chunk
      for (int i = 0; i < 100; i++) drive(pattern(4, i), 1'b1, 1'b1, 1'b0);
      drive(8'hAB, 1'b1, 1'b1, 1'b1);
      drive(8'h00, 1'b0, 1'b0, 1'b0);
      check(res_word == last_word, "R8", "clear leaves word", res_word, last_word);
      check(res_vld == 1'b0, "R8", "clear gives no pulse", 32'(res_vld), 32'h0);
      drive_chunk(2, 1'b0); idle(3);
      drive_chunk(0, 1'b1); idle(5);

      check(exp_q.size() == 0, "R3", "results outstanding", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL R3 watchdog: actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule